// File: doc/BRIEF.md
# Saturating Dual Accumulator with Rounded Store

This block is the accumulate stage of a fixed-point signal-processing datapath. It holds two 40-bit signed accumulators, named A and B. Each one carries a 1.31 fractional value under eight guard bits, with bit 39 as the sign. On an add strobe, a signed 40-bit operand is summed into the selected accumulator. The block watches two overflow boundaries. The first is the edge of the 1.31 range, where the value spills into the guard bits. The second is the edge of the full 40-bit range, which is catastrophic overflow. When saturation is enabled, the result is clamped at one of these two boundaries instead of wrapping.

A store strobe converts the selected accumulator to a 1.15 word for write-back. The value is rounded first, either conventionally or convergently, and then clamped to the 16-bit range. A store never changes either accumulator. Each accumulator has a sticky catastrophic-overflow flag, cleared by its own strobe. Each also has a live flag that shows whether the current contents lie outside the 1.31 range.

Top module: `dsp_acc_unit`

## Requirements
- R1: With `add_i` high, the accumulator picked by `sel_b_i` (0 = A, 1 = B) takes the new result on the next edge, and the other accumulator holds its value. With `add_i` low, both accumulators hold.
- R2: With `sat_en_i` low, the result is the 40-bit sum reduced modulo 2^40, which means it wraps.
- R3: `ova_o` / `ovb_o` is high exactly when bits 39..31 of that accumulator are not all equal, that is, when the value is outside the 1.31 range.
- R4: When the exact sum of an add falls outside the signed 40-bit range, `sa_o` (A) or `sb_o` (B) is set on the next edge, with or without saturation. The flag then stays set.
- R5: `clr_sa_i` / `clr_sb_i` clears the matching flag on the next edge. If a new catastrophic overflow on that accumulator arrives in the same cycle, the flag stays set.
- R6: With `sat_en_i` high and `sat_mode_i` = 0, an exact sum above the 1.31 range loads 0x007FFFFFFF, and one below it loads 0xFF80000000.
- R7: With `sat_en_i` high and `sat_mode_i` = 1, an exact sum above the 40-bit range loads 0x7FFFFFFFFF, and one below it loads 0x8000000000. Sums inside the 40-bit range are kept unchanged.
- R8: With `rnd_mode_i` = 0 (conventional rounding), the store word is bits 31..16 of the selected accumulator, plus one when bit 15 is set.
- R9: With `rnd_mode_i` = 1 (convergent rounding), the result rounds up when bits 15..0 exceed 0x8000 and truncates when they are below 0x8000. When they equal 0x8000, it adds one only if bit 16 is 1.
- R10: If the rounded value is above +0x7FFF, the store word becomes 0x7FFF. If it is below -0x8000, the store word becomes 0x8000.
- R11: `store_o` takes the converted value of the accumulator selected by `sel_b_i`, using its contents before the edge, one edge after `store_i`. Without `store_i` it holds. A store never changes an accumulator.
- R12: After reset, both accumulators, both sticky flags and `store_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 40 | Signed operand to add |
| sel_b_i | input | 1 | Accumulator select for add and store: 0 = A, 1 = B |
| add_i | input | 1 | Add strobe |
| sat_en_i | input | 1 | Saturation enable for the add |
| sat_mode_i | input | 1 | 0 = clamp to 1.31 range, 1 = clamp to 40-bit range |
| rnd_mode_i | input | 1 | 0 = conventional rounding, 1 = convergent rounding |
| store_i | input | 1 | Store strobe |
| clr_sa_i | input | 1 | Clear strobe for the A sticky flag |
| clr_sb_i | input | 1 | Clear strobe for the B sticky flag |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| store_o | output | 16 | Rounded and saturated 1.15 store word |
| ova_o | output | 1 | A is outside the 1.31 range |
| ovb_o | output | 1 | B is outside the 1.31 range |
| sa_o | output | 1 | Sticky catastrophic-overflow flag for A |
| sb_o | output | 1 | Sticky catastrophic-overflow flag for B |

## Verification
The bench builds the block with its default widths: 40-bit accumulators, 8 guard bits and a 16-bit store word. At these widths, every boundary fits inside a 64-bit integer model. That covers both clamp limits and the catastrophic wrap at 2^39. The default store width puts the rounding tie bit at position 16. So the conventional-against-convergent tie at 0x8000 can be set up directly with a load-by-difference helper, as can the clamp edges at ±0x8000 of the rounded word. Directed cases hit each boundary. A long randomised run then drives operand magnitudes spread across all shift amounts, so both overflow kinds and both clear-versus-set orderings occur many times.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;

    // Clamp boundary used when saturation is enabled
    typedef enum logic {
        SAT_FRAC = 1'b0,   // clamp to the 1.31 range
        SAT_FULL = 1'b1    // clamp to the full 40-bit range
    } sat_mode_e;

    // Rounding rule on the store path
    typedef enum logic {
        RND_CONV = 1'b0,   // round half up
        RND_EVEN = 1'b1    // convergent: ties go to even
    } rnd_mode_e;

    localparam int unsigned NUM_ACC = 2;

endpackage

// File: rtl/dsp_acc_lane.sv
module dsp_acc_lane
    import dsp_acc_pkg::*;
#(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned GUARD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [ACC_W-1:0] op,
    input  logic             sat_en,
    input  sat_mode_e        sat_mode,
    input  logic             clr,
    output logic [ACC_W-1:0] acc,
    output logic             guard_ovf,
    output logic             sticky
);
    localparam int unsigned FRAC_W = ACC_W - GUARD_W;
    localparam int unsigned SUM_W  = ACC_W + 1;
    localparam int unsigned CHK_W  = GUARD_W + 2;
    localparam int unsigned TOP_W  = GUARD_W + 1;

    localparam logic [ACC_W-1:0] MAX_FRAC = {{TOP_W{1'b0}}, {(FRAC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_FRAC = {{TOP_W{1'b1}}, {(FRAC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] MAX_FULL = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_FULL = {1'b1, {(ACC_W-1){1'b0}}};

    logic [SUM_W-1:0] sum;
    logic             cat_ovf;
    logic             frac_out;
    logic [ACC_W-1:0] nxt;

    // Exact sum with one extra sign bit
    assign sum      = {acc[ACC_W-1], acc} + {op[ACC_W-1], op};
    assign cat_ovf  = sum[ACC_W] ^ sum[ACC_W-1];
    assign frac_out = sum[ACC_W -: CHK_W] != {CHK_W{sum[ACC_W]}};

    always_comb begin
        nxt = sum[ACC_W-1:0];
        if (sat_en) begin
            unique case (sat_mode)
                SAT_FRAC: if (frac_out) nxt = sum[ACC_W] ? MIN_FRAC : MAX_FRAC;
                SAT_FULL: if (cat_ovf)  nxt = sum[ACC_W] ? MIN_FULL : MAX_FULL;
                default:  nxt = sum[ACC_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            sticky <= 1'b0;
        end else begin
            if (add_en) acc <= nxt;
            // a new overflow beats a clear in the same cycle
            sticky <= (sticky && !clr) || (add_en && cat_ovf);
        end
    end

    assign guard_ovf = acc[ACC_W-1 -: TOP_W] != {TOP_W{acc[ACC_W-1]}};

endmodule

// File: rtl/dsp_acc_round.sv
module dsp_acc_round
    import dsp_acc_pkg::*;
#(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned GUARD_W = 8,
    parameter int unsigned STORE_W = 16
) (
    input  logic [ACC_W-1:0]   acc,
    input  rnd_mode_e          mode,
    output logic [STORE_W-1:0] word
);
    localparam int unsigned FRAC_W = ACC_W - GUARD_W;
    localparam int unsigned RB     = FRAC_W - STORE_W;
    localparam int unsigned HI_W   = ACC_W - RB;
    localparam int unsigned CW     = HI_W - STORE_W + 2;
    localparam logic [RB-1:0] HALF = {1'b1, {(RB-1){1'b0}}};
    localparam logic [STORE_W-1:0] W_MAX = {1'b0, {(STORE_W-1){1'b1}}};
    localparam logic [STORE_W-1:0] W_MIN = {1'b1, {(STORE_W-1){1'b0}}};

    logic [HI_W-1:0] hi;
    logic [RB-1:0]   low;
    logic            up;
    logic [HI_W:0]   rnd;
    logic            oor;

    assign hi  = acc[ACC_W-1:RB];
    assign low = acc[RB-1:0];

    always_comb begin
        up = 1'b0;
        unique case (mode)
            RND_CONV: up = low[RB-1];
            RND_EVEN: up = (low > HALF) || ((low == HALF) && hi[0]);
            default:  up = 1'b0;
        endcase
    end

    assign rnd  = {hi[HI_W-1], hi} + {{HI_W{1'b0}}, up};
    assign oor  = rnd[HI_W -: CW] != {CW{rnd[HI_W]}};
    assign word = oor ? (rnd[HI_W] ? W_MIN : W_MAX) : rnd[STORE_W-1:0];

endmodule

// File: rtl/dsp_acc_unit.sv
module dsp_acc_unit
    import dsp_acc_pkg::*;
#(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned GUARD_W = 8,
    parameter int unsigned STORE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   op_i,
    input  logic               sel_b_i,
    input  logic               add_i,
    input  logic               sat_en_i,
    input  logic               sat_mode_i,
    input  logic               rnd_mode_i,
    input  logic               store_i,
    input  logic               clr_sa_i,
    input  logic               clr_sb_i,
    output logic [ACC_W-1:0]   acc_a_o,
    output logic [ACC_W-1:0]   acc_b_o,
    output logic [STORE_W-1:0] store_o,
    output logic               ova_o,
    output logic               ovb_o,
    output logic               sa_o,
    output logic               sb_o
);
    logic [ACC_W-1:0]   acc_q  [NUM_ACC];
    logic [NUM_ACC-1:0] add_v;
    logic [NUM_ACC-1:0] clr_v;
    logic [NUM_ACC-1:0] gov_v;
    logic [NUM_ACC-1:0] stk_v;
    logic [ACC_W-1:0]   st_src;
    logic [STORE_W-1:0] st_word;
    logic [STORE_W-1:0] store_q;

    assign add_v = {add_i & sel_b_i, add_i & ~sel_b_i};
    assign clr_v = {clr_sb_i, clr_sa_i};

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_lane
        dsp_acc_lane #(
            .ACC_W   (ACC_W),
            .GUARD_W (GUARD_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .add_en    (add_v[g]),
            .op        (op_i),
            .sat_en    (sat_en_i),
            .sat_mode  (sat_mode_e'(sat_mode_i)),
            .clr       (clr_v[g]),
            .acc       (acc_q[g]),
            .guard_ovf (gov_v[g]),
            .sticky    (stk_v[g])
        );
    end

    assign st_src = sel_b_i ? acc_q[1] : acc_q[0];

    dsp_acc_round #(
        .ACC_W   (ACC_W),
        .GUARD_W (GUARD_W),
        .STORE_W (STORE_W)
    ) u_round (
        .acc  (st_src),
        .mode (rnd_mode_e'(rnd_mode_i)),
        .word (st_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       store_q <= '0;
        else if (store_i) store_q <= st_word;
    end

    assign acc_a_o = acc_q[0];
    assign acc_b_o = acc_q[1];
    assign store_o = store_q;
    assign ova_o   = gov_v[0];
    assign ovb_o   = gov_v[1];
    assign sa_o    = stk_v[0];
    assign sb_o    = stk_v[1];

endmodule

// File: rtl/dsp_acc_unit_chk.sv
module dsp_acc_unit_chk #(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned STORE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ACC_W-1:0]   op_i,
    input logic               sel_b_i,
    input logic               add_i,
    input logic               sat_en_i,
    input logic               sat_mode_i,
    input logic               rnd_mode_i,
    input logic               store_i,
    input logic               clr_sa_i,
    input logic               clr_sb_i,
    input logic [ACC_W-1:0]   acc_a_o,
    input logic [ACC_W-1:0]   acc_b_o,
    input logic [STORE_W-1:0] store_o,
    input logic               ova_o,
    input logic               ovb_o,
    input logic               sa_o,
    input logic               sb_o
);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !add_i |=> ($stable(acc_a_o) && $stable(acc_b_o)));

    assert_unsel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && !sel_b_i) |=> $stable(acc_b_o));

    assert_sticky_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_o && !clr_sa_i) |=> sa_o);

    assert_sticky_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_o && !clr_sb_i) |=> sb_o);

    assert_in_frac_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && sat_en_i && !sat_mode_i && !sel_b_i) |=> !ova_o);

    assert_store_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !store_i |=> $stable(store_o));

    assert_clear_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sa_i && !add_i) |=> !sa_o);

endmodule

bind dsp_acc_unit dsp_acc_unit_chk #(.ACC_W(ACC_W), .STORE_W(STORE_W)) u_chk (.*);

// File: tb/dsp_acc_unit_tb.sv
module dsp_acc_unit_tb;
    localparam longint M39 = 64'sd549755813887;
    localparam longint N39 = -64'sd549755813888;
    localparam longint M31 = 64'sd2147483647;
    localparam longint N31 = -64'sd2147483648;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] op_i = '0;
    logic        sel_b_i = 0, add_i = 0, sat_en_i = 0, sat_mode_i = 0;
    logic        rnd_mode_i = 0, store_i = 0, clr_sa_i = 0, clr_sb_i = 0;
    logic [39:0] acc_a_o, acc_b_o;
    logic [15:0] store_o;
    logic        ova_o, ovb_o, sa_o, sb_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    longint    m_acc [2];
    bit        m_stk [2];
    logic [15:0] m_st;

    always #2.5 clk = ~clk;

    dsp_acc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_b_i(sel_b_i), .add_i(add_i),
        .sat_en_i(sat_en_i), .sat_mode_i(sat_mode_i), .rnd_mode_i(rnd_mode_i),
        .store_i(store_i), .clr_sa_i(clr_sa_i), .clr_sb_i(clr_sb_i),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .store_o(store_o),
        .ova_o(ova_o), .ovb_o(ovb_o), .sa_o(sa_o), .sb_o(sb_o)
    );

    function automatic longint sx40(input logic [39:0] v);
        return {{24{v[39]}}, v};
    endfunction

    function automatic logic [15:0] ref_store(input longint a, input bit even);
        longint h = a >>> 16;
        longint lo = a & 64'hFFFF;
        longint r;
        bit up;
        if (even) up = (lo > 32768) || (lo == 32768 && h[0]);
        else      up = (lo >= 32768);
        r = h + longint'(up);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r[15:0];
    endfunction

    task automatic chk(input string what, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk("acc_a", req, acc_a_o, m_acc[0][39:0]);
        chk("acc_b", req, acc_b_o, m_acc[1][39:0]);
        chk("ova",   req, {39'd0, ova_o}, {39'd0, (m_acc[0] > M31 || m_acc[0] < N31)});
        chk("ovb",   req, {39'd0, ovb_o}, {39'd0, (m_acc[1] > M31 || m_acc[1] < N31)});
        chk("sa",    req, {39'd0, sa_o}, {39'd0, m_stk[0]});
        chk("sb",    req, {39'd0, sb_o}, {39'd0, m_stk[1]});
        chk("store", req, {24'd0, store_o}, {24'd0, m_st});
    endtask

    // one clock: drive at negedge, update model, compare at next negedge
    task automatic cyc(input bit sb, input bit add, input logic [39:0] op, input bit se,
                       input bit sm, input bit st, input bit rm, input bit ca, input bit cb,
                       input string req);
        int s = sb ? 1 : 0;
        longint sum, res;
        bit cat = 0;
        sel_b_i = sb; add_i = add; op_i = op; sat_en_i = se; sat_mode_i = sm;
        store_i = st; rnd_mode_i = rm; clr_sa_i = ca; clr_sb_i = cb;
        if (st) m_st = ref_store(m_acc[s], rm);
        if (add) begin
            sum = m_acc[s] + sx40(op);
            cat = (sum > M39) || (sum < N39);
            if (se && !sm && (sum > M31 || sum < N31)) res = (sum > 0) ? M31 : N31;
            else if (se && sm && cat)                  res = (sum > 0) ? M39 : N39;
            else                                        res = sx40(sum[39:0]);
            m_acc[s] = res;
        end
        m_stk[0] = (m_stk[0] && !ca) || (add && !sb && cat);
        m_stk[1] = (m_stk[1] && !cb) || (add && sb && cat);
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic do_add(input bit sb, input longint v, input bit se, input bit sm, input string req);
        cyc(sb, 1, v[39:0], se, sm, 0, 0, 0, 0, req);
    endtask

    // bring an accumulator to an exact value by adding the difference
    task automatic load(input bit sb, input longint v, input string req);
        longint d = v - m_acc[sb ? 1 : 0];
        cyc(sb, 1, d[39:0], 0, 0, 0, 0, 1, 1, req);
    endtask

    task automatic do_store(input bit sb, input bit rm, input string req);
        cyc(sb, 0, '0, 0, 0, 1, rm, 0, 0, req);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_acc[0] = 0; m_acc[1] = 0; m_stk[0] = 0; m_stk[1] = 0; m_st = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R12");

        // R1: selected accumulator only, idle holds
        do_add(0, 64'sh123456, 0, 0, "R1");
        do_add(1, -64'sh10000, 0, 0, "R1");
        cyc(0, 0, 40'hFFFFFFFFFF, 0, 0, 0, 0, 0, 0, "R1");

        // R3: leaving and re-entering the 1.31 range
        do_add(0, 64'sh80000000, 0, 0, "R3");
        do_add(0, -64'sh80000000, 0, 0, "R3");
        load(1, -64'sh80000001, "R3");

        // R2, R4: wrap at 2^39 and sticky flag
        load(0, M39, "R2");
        do_add(0, 1, 0, 0, "R2");
        do_add(0, 5, 0, 0, "R4");
        load(1, N39, "R4");
        do_add(1, -1, 0, 0, "R4");

        // R5: clear, and clear racing a new overflow
        cyc(0, 0, '0, 0, 0, 0, 0, 1, 0, "R5");
        load(0, M39, "R5");
        cyc(0, 1, 40'd1, 0, 0, 0, 0, 1, 0, "R5");
        cyc(1, 0, '0, 0, 0, 0, 0, 0, 1, "R5");

        // R6: clamp to 1.31 range
        load(0, 64'sh7FFF0000, "R6");
        do_add(0, 64'sh10000000, 1, 0, "R6");
        load(1, -64'sh7FFF0000, "R6");
        do_add(1, -64'sh10000000, 1, 0, "R6");
        load(0, M39, "R6");
        do_add(0, M39, 1, 0, "R6");

        // R7: clamp to 40-bit range, in-range sums untouched
        load(0, M39 - 2, "R7");
        do_add(0, 64'sh100, 1, 1, "R7");
        load(1, N39 + 2, "R7");
        do_add(1, -64'sh100, 1, 1, "R7");
        do_add(1, 64'sh80000000, 1, 1, "R7");

        // R8, R9: rounding ties and near-ties
        load(0, 64'sh12348000, "R8");
        do_store(0, 0, "R8");
        do_store(0, 1, "R9");
        load(0, 64'sh12358000, "R9");
        do_store(0, 1, "R9");
        load(0, 64'sh12348001, "R9");
        do_store(0, 1, "R9");
        load(0, 64'sh12347FFF, "R8");
        do_store(0, 0, "R8");
        do_store(0, 1, "R9");
        load(1, -64'sh8000, "R9");
        do_store(1, 0, "R8");
        do_store(1, 1, "R9");

        // R10: store clamps
        load(0, 64'sh7FFF8000, "R10");
        do_store(0, 0, "R10");
        load(1, -64'sh80010000, "R10");
        do_store(1, 1, "R10");
        load(0, M39, "R10");
        do_store(0, 1, "R10");

        // R11: store with add in the same cycle uses old contents
        load(1, 64'sh11118000, "R11");
        cyc(1, 1, 40'h0000100000, 0, 0, 1, 0, 0, 0, "R11");
        cyc(0, 0, '0, 0, 0, 0, 1, 0, 0, "R11");

        // randomised mix across all requirements
        for (int i = 0; i < 3000; i++) begin
            logic signed [39:0] t;
            int sh;
            t  = {$urandom(), $urandom()};
            sh = $urandom_range(0, 39);
            t  = t >>> sh;
            cyc($urandom_range(0, 1), ($urandom_range(0, 3) != 0), t,
                $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 1), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                "R1 R2 R4 R5 R6 R7 R9 R10");
        end

        finish_run();
    end
endmodule